// File: doc/BRIEF.md
# Synchronization Window Address-Map Registers

This block holds the two 64-bit configuration words that place a window of inter-thread synchronization cells in the address space. Software reaches the words through a simple register port with an 8-byte stride. The block turns the stored fields into a window base, a window size, an enable, a per-cell entry grain with its stride shift, and the total cell count.

Whenever a write leaves a word with a new value, a one-cycle reconfigure pulse tells the surrounding logic to re-place the window. A registered probe decoder reports whether a given bus address falls inside the window while the window is enabled. The storage cells themselves and the bus protocol are outside this block.

Top module: `syncwin_map_regs`

## Requirements
- R1: The register index is `reg_addr >> 3`. Index 0 reads back word A and index 1 reads back word B. `reg_rdata` shows the addressed word on the cycle after the address is presented.
- R2: A read of any index other than 0 or 1 returns zero.
- R3: A write to index 0 updates only bits 31:10 (base) and bit 0 (enable) of word A. All other bits keep their old value. `win_base` is bits 31:10 with ten zero bits below them, and `win_en` is bit 0. Both follow the write at the same clock edge.
- R4: A write to index 1 updates only bits 16:10 (size mask) and bits 2:0 (entry grain) of word B. All other bits keep their old value.
- R5: A write to an index other than 0 or 1 changes no stored word and no output, and raises no reconfigure pulse.
- R6: `reconfig` is high for exactly the one cycle after a write edge that left word A or word B with a value different from its previous value. It stays low otherwise, including for writes that store the same value again.
- R7: The candidate window size is 1024 plus word B masked with 0x1FC00 (the field is taken in place, not shifted). `win_size` takes the candidate only when it is a power of two; otherwise `win_size` keeps its previous value.
- R8: After reset, word A is zero. Word B is 0xC00 plus the cell count placed at bit 20. `win_size` is 4096, `win_en` is 0, and `reconfig` and `probe_hit` are 0.
- R9: `entry_grain` is word B bits 2:0, and `stride_shift` is 7 plus `entry_grain`, so the smallest cell stride is 128 bytes.
- R10: `probe_hit`, one cycle after `probe_addr` is presented, is 1 exactly when `win_en` is 1 and `win_base <= probe_addr < win_base + win_size`.
- R11: `cell_count` shows the count field of word B, which resets to the `N_CELLS` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (6) | Register byte address; index is bits above 3 |
| reg_wdata | input | 64 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 64 | Registered read data |
| win_base | output | 32 | Window base address |
| win_size | output | SIZE_W (18) | Window size in bytes |
| win_en | output | 1 | Window enable |
| entry_grain | output | 3 | Entry grain field |
| stride_shift | output | 4 | Cell stride shift (7 + grain) |
| cell_count | output | CNT_W (8) | Total cell count field |
| reconfig | output | 1 | One-cycle pulse when a word changed |
| probe_addr | input | 32 | Address to test against the window |
| probe_hit | output | 1 | Registered window hit |

## Verification
The case that is hardest to reach from the ports is a size-mask write whose candidate size is not a power of two. The word must take the new value and `reconfig` must pulse, yet `win_size` must hold its old value. The bench sweeps all 128 values of the mask field, each with the grain bits and disallowed bits set. After each write it compares size, grain, stride, the pulse and the read-back against an arithmetic model. It then writes the same value again to confirm that no pulse follows. The probe is checked one byte on either side of both window edges, and again with the window disabled.

// File: rtl/syncwin_pkg.sv
package syncwin_pkg;
  localparam int WORD_W = 64;
  localparam int BUS_W  = 32;
  // writable bits of word A: base 31:10, enable 0
  localparam logic [WORD_W-1:0] WA_MASK = 64'h0000_0000_FFFF_FC01;
  // writable bits of word B: size mask 16:10, grain 2:0
  localparam logic [WORD_W-1:0] WB_MASK = 64'h0000_0000_0001_FC07;
  localparam int BASE_LSB   = 10;
  localparam int SZMASK_MSB = 16;
  localparam int GRAIN_W    = 3;
  localparam int COUNT_LSB  = 20;
  localparam int MIN_SIZE   = 1024;
  localparam int DEF_SIZE   = 4096;
  localparam int STRIDE_MIN = 7;

  function automatic logic is_pow2(input logic [31:0] v);
    return (v != 0) && ((v & (v - 32'd1)) == 32'd0);
  endfunction
endpackage

// File: rtl/syncwin_word.sv
module syncwin_word
  import syncwin_pkg::*;
#(
  parameter logic [WORD_W-1:0] MASK  = '0,
  parameter logic [WORD_W-1:0] RESET = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] value_q,
  output logic [WORD_W-1:0] value_nxt,
  output logic              changed
);
  logic [WORD_W-1:0] merged;

  always_comb begin
    merged    = (wdata & MASK) | (value_q & ~MASK);
    changed   = wr_en && (merged != value_q);
    value_nxt = wr_en ? merged : value_q;
  end

  always_ff @(posedge clk) begin
    if (rst) value_q <= RESET;
    else     value_q <= value_nxt;
  end
endmodule

// File: rtl/syncwin_window.sv
module syncwin_window
  import syncwin_pkg::*;
#(
  parameter int SIZE_W = 18
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [BUS_W-1:BASE_LSB]     base_nxt,
  input  logic                        en_nxt,
  input  logic [SZMASK_MSB:BASE_LSB]  szmask_nxt,
  input  logic [GRAIN_W-1:0]          grain_nxt,
  input  logic [BUS_W-1:0]            probe_addr,
  output logic [BUS_W-1:0]            win_base,
  output logic [SIZE_W-1:0]           win_size,
  output logic                        win_en,
  output logic [GRAIN_W-1:0]          entry_grain,
  output logic [3:0]                  stride_shift,
  output logic                        probe_hit
);
  localparam int FLD_W = SZMASK_MSB - BASE_LSB + 1;

  logic [31:0]     cand;
  logic [BUS_W:0]  win_end;
  logic            hit_d;

  always_comb begin
    cand    = 32'(MIN_SIZE) + {{(32-FLD_W-BASE_LSB){1'b0}}, szmask_nxt, {BASE_LSB{1'b0}}};
    win_end = {1'b0, win_base} + {{(BUS_W+1-SIZE_W){1'b0}}, win_size};
    hit_d   = win_en && (probe_addr >= win_base) &&
              ({1'b0, probe_addr} < win_end);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_base     <= '0;
      win_en       <= 1'b0;
      win_size     <= SIZE_W'(DEF_SIZE);
      entry_grain  <= '0;
      stride_shift <= 4'(STRIDE_MIN);
      probe_hit    <= 1'b0;
    end else begin
      win_base     <= {base_nxt, {BASE_LSB{1'b0}}};
      win_en       <= en_nxt;
      if (is_pow2(cand)) win_size <= cand[SIZE_W-1:0];
      entry_grain  <= grain_nxt;
      stride_shift <= 4'(STRIDE_MIN) + {1'b0, grain_nxt};
      probe_hit    <= hit_d;
    end
  end
endmodule

// File: rtl/syncwin_map_regs.sv
module syncwin_map_regs
  import syncwin_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int N_CELLS = 32,
  parameter int CNT_W   = 8,
  parameter int SIZE_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  input  logic              reg_we,
  output logic [63:0]       reg_rdata,
  output logic [31:0]       win_base,
  output logic [SIZE_W-1:0] win_size,
  output logic              win_en,
  output logic [2:0]        entry_grain,
  output logic [3:0]        stride_shift,
  output logic [CNT_W-1:0]  cell_count,
  output logic              reconfig,
  input  logic [31:0]       probe_addr,
  output logic              probe_hit
);
  localparam int IDX_W = ADDR_W - 3;
  localparam int N_WORDS = 2;
  localparam logic [WORD_W-1:0] WB_RESET =
    ((WORD_W'(DEF_SIZE) - 1) & WB_MASK & ~WORD_W'(7)) |
    (WORD_W'(N_CELLS) << COUNT_LSB);

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word_q   [N_WORDS];
  logic [WORD_W-1:0] word_nxt [N_WORDS];
  logic [N_WORDS-1:0] chg;
  logic [WORD_W-1:0] rd_d;

  assign idx = reg_addr[ADDR_W-1:3];

  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    syncwin_word #(
      .MASK  (i == 0 ? WA_MASK : WB_MASK),
      .RESET (i == 0 ? '0 : WB_RESET)
    ) word_i (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (reg_we && (idx == IDX_W'(i))),
      .wdata     (reg_wdata),
      .value_q   (word_q[i]),
      .value_nxt (word_nxt[i]),
      .changed   (chg[i])
    );
  end

  syncwin_window #(.SIZE_W(SIZE_W)) window_i (
    .clk          (clk),
    .rst          (rst),
    .base_nxt     (word_nxt[0][BUS_W-1:BASE_LSB]),
    .en_nxt       (word_nxt[0][0]),
    .szmask_nxt   (word_nxt[1][SZMASK_MSB:BASE_LSB]),
    .grain_nxt    (word_nxt[1][GRAIN_W-1:0]),
    .probe_addr   (probe_addr),
    .win_base     (win_base),
    .win_size     (win_size),
    .win_en       (win_en),
    .entry_grain  (entry_grain),
    .stride_shift (stride_shift),
    .probe_hit    (probe_hit)
  );

  always_comb begin
    case (idx)
      IDX_W'(0): rd_d = word_q[0];
      IDX_W'(1): rd_d = word_q[1];
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      reconfig  <= 1'b0;
    end else begin
      reg_rdata <= rd_d;
      reconfig  <= |chg;
    end
  end

  assign cell_count = word_q[1][COUNT_LSB +: CNT_W];
endmodule

// File: rtl/syncwin_map_regs_chk.sv
module syncwin_map_regs_chk #(
  parameter int ADDR_W = 6,
  parameter int SIZE_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [31:0]       win_base,
  input logic [SIZE_W-1:0] win_size,
  input logic              win_en,
  input logic [3:0]        stride_shift,
  input logic              reconfig,
  input logic              probe_hit
);
  a_r6_pulse_needs_write: assert property (@(posedge clk) disable iff (rst)
    reconfig |-> $past(reg_we));

  a_r5_foreign_index_quiet: assert property (@(posedge clk) disable iff (rst)
    (reg_we && (reg_addr[ADDR_W-1:3] > 1)) |=> (!reconfig && $stable(win_size) && $stable(win_base)));

  a_r3_base_holds_without_write: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && (reg_addr[ADDR_W-1:3] == 0)) |=> ($stable(win_base) && $stable(win_en)));

  a_r7_size_pow2: assert property (@(posedge clk) disable iff (rst)
    $countones(win_size) == 1);

  a_r9_stride_range: assert property (@(posedge clk) disable iff (rst)
    (stride_shift >= 4'd7) && (stride_shift <= 4'd14));

  a_r10_hit_needs_enable: assert property (@(posedge clk) disable iff (rst)
    probe_hit |-> $past(win_en));
endmodule

bind syncwin_map_regs syncwin_map_regs_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .reg_addr     (reg_addr),
  .reg_we       (reg_we),
  .win_base     (win_base),
  .win_size     (win_size),
  .win_en       (win_en),
  .stride_shift (stride_shift),
  .reconfig     (reconfig),
  .probe_hit    (probe_hit)
);

// File: tb/syncwin_map_regs_tb.sv
module syncwin_map_regs_tb_top;
  localparam int ADDR_W = 6, N_CELLS = 32, CNT_W = 8, SIZE_W = 18;

  logic clk = 0, rst = 1;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic reg_we = 0;
  logic [31:0] win_base, probe_addr = '0;
  logic [SIZE_W-1:0] win_size;
  logic win_en, reconfig, probe_hit;
  logic [2:0] entry_grain;
  logic [3:0] stride_shift;
  logic [CNT_W-1:0] cell_count;

  int checks = 0, errors = 0;
  logic [63:0] ma, mb;
  longint msz;

  always #5 clk = ~clk;

  syncwin_map_regs #(.ADDR_W(ADDR_W), .N_CELLS(N_CELLS), .CNT_W(CNT_W), .SIZE_W(SIZE_W)) dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .win_base(win_base), .win_size(win_size), .win_en(win_en),
    .entry_grain(entry_grain), .stride_shift(stride_shift), .cell_count(cell_count),
    .reconfig(reconfig), .probe_addr(probe_addr), .probe_hit(probe_hit));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write one word, update model, check the outputs that follow the edge
  task automatic wr(input int idx, input logic [63:0] d);
    logic [63:0] old, nw;
    longint cand;
    bit ch;
    ch = 0;
    @(negedge clk);
    reg_addr = ADDR_W'(idx << 3); reg_wdata = d; reg_we = 1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 0;
    if (idx == 0) begin
      old = ma; nw = (d & 64'hFFFF_FC01) | (ma & ~64'hFFFF_FC01); ch = (nw != old); ma = nw;
    end else if (idx == 1) begin
      old = mb; nw = (d & 64'h1FC07) | (mb & ~64'h1FC07); ch = (nw != old); mb = nw;
      cand = 1024 + longint'(mb & 64'h1FC00);
      if ((cand & (cand - 1)) == 0) msz = cand;
    end
    chk("R6 reconfig", reconfig, ch);
    chk("R3 base", win_base, ma & 64'hFFFF_FC00);
    chk("R3 enable", win_en, ma & 1);
    chk("R7 size", win_size, msz);
    chk("R9 grain", entry_grain, mb & 7);
    chk("R9 stride", stride_shift, 7 + (mb & 7));
  endtask

  task automatic rd(input int idx);
    @(negedge clk);
    reg_addr = ADDR_W'(idx << 3);
    @(posedge clk);
    @(negedge clk);
    if (idx == 0)      chk("R1 read A", reg_rdata, ma);
    else if (idx == 1) chk("R1 read B", reg_rdata, mb);
    else               chk("R2 read other", reg_rdata, 0);
  endtask

  task automatic probe(input logic [31:0] a);
    longint e;
    @(negedge clk);
    probe_addr = a;
    @(posedge clk);
    @(negedge clk);
    e = (ma & 1) && (a >= (ma & 64'hFFFF_FC00)) && (longint'(a) < longint'(ma & 64'hFFFF_FC00) + msz);
    chk("R10 hit", probe_hit, e);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ma = 0; mb = 64'hC00 | (64'(N_CELLS) << 20); msz = 4096;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R8 reset state
    chk("R8 size", win_size, 4096);
    chk("R8 enable", win_en, 0);
    chk("R8 reconfig", reconfig, 0);
    chk("R8 hit", probe_hit, 0);
    chk("R11 count", cell_count, N_CELLS);
    rd(0); rd(1);
    for (int i = 2; i < 8; i++) rd(i);
    // R4/R7 sweep of all size-mask values with disallowed bits set
    for (int f = 0; f < 128; f++) begin
      wr(1, 64'hFFFF_FFFF_FFF0_0000 | 64'((f << 10) | (f & 7)) | 64'h3F8);
      rd(1);
      wr(1, 64'hFFFF_FFFF_FFF0_0000 | 64'((f << 10) | (f & 7)) | 64'h3F8); // R6 same value
      chk("R11 count kept", cell_count, N_CELLS);
    end
    // R3 word A patterns
    for (int i = 0; i < 24; i++) begin
      wr(0, {32'hDEAD_BEEF, 32'(i * 32'h9E37_79B1)});
      rd(0);
    end
    wr(0, 64'hFFFF_FFFF_FFFF_FFFF); rd(0);
    wr(0, 64'h0); rd(0);
    // R5 foreign index writes
    for (int i = 2; i < 8; i++) begin
      wr(i, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(0); rd(1);
    end
    // R10 hit edges: size 4096 then 128K
    wr(1, 64'hC00);
    wr(0, 64'h0001_0001);
    probe(32'h0000_FFFF); probe(32'h0001_0000);
    probe(32'h0001_0FFF); probe(32'h0001_1000);
    wr(1, 64'h1FC00);
    probe(32'h0003_0000); probe(32'h0002_FFFF);
    wr(0, 64'h0001_0000);
    probe(32'h0001_0000); probe(32'h0001_8000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule